// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate Controller

This block sits in series with the active-low chip enable of a battery-backed static RAM. It stops the memory from being written while the supply is collapsing or while the system reset is active. In normal operation it passes the incoming enable through to the memory with a short, fixed latency. When a fault appears, it closes the path. A fault is the reset generator reporting an active reset, or the supply comparator reporting that the supply is below its threshold.

A hard cut in the middle of a memory access could corrupt the word being written. To avoid this, the gate does not close at once when a fault arrives while an access is in progress. It holds the enable low until the processor ends the access or until a bounded grace window runs out, whichever happens first. After the gate has closed, it stays closed for the rest of that fault episode. It opens again only when the fault has cleared completely, which covers the whole reset timeout that the reset generator applies on power-up.

The incoming enable comes from another timing domain. It passes through a synchronizer of configurable depth before the gate uses it. The grace window is a parameter given in clock cycles, for example 16 µs times the clock frequency.

Top module: `pfail_ce_gate`

## Requirements
- R1: While `rst_n` is low, `ce_out_n` is 1 and `gate_open` is 0.
- R2: After `rst_n` is released, the gate remains closed (`ce_out_n` = 1, `gate_open` = 0) for as long as a fault persists, whatever the value of `ce_in_n`. A fault means `sys_reset` = 1 or `supply_ok` = 0.
- R3: With no fault present and the gate open, `ce_out_n` reproduces every transition of `ce_in_n`, delayed by SYNC_STAGES+1 rising clock edges (3 edges at the default depth).
- R4: When the gate is open with the synchronized enable high, the first edge that samples a fault closes the gate: after that edge `ce_out_n` = 1 and `gate_open` = 0.
- R5: When the first edge that samples a fault finds the synchronized enable low, `ce_out_n` stays 0 and `gate_open` stays 1. This grace period lasts until one of two events, whichever comes first. Either the synchronized enable goes high, and the gate closes at that edge. Or GRACE_CYC edges after the entry edge, the gate closes even though the enable is still low.
- R6: Once the gate has closed during a fault, a return of `ce_in_n` to 0 does not reopen it while the fault persists.
- R7: The first edge that samples no fault (`sys_reset` = 0 and `supply_ok` = 1) reopens the gate. After that edge `gate_open` = 1 and `ce_out_n` equals the synchronized enable.
- R8: `ce_out_n` is 0 only while `gate_open` is 1.
- R9: A low `supply_ok` with `sys_reset` = 0 closes the gate in the same way as an active reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | High while the supply is above the reset threshold |
| sys_reset | input | 1 | High while the reset generator holds the system in reset |
| ce_in_n | input | 1 | Incoming active-low chip enable, asynchronous |
| ce_out_n | output | 1 | Gated active-low chip enable to the memory |
| gate_open | output | 1 | 1 while the gate passes the enable, 0 while it blocks |

## Verification
A walking table of enable patterns checks the pass path with no fault present. The patterns are isolated low and high pulses one clock wide, long runs, and alternating values. Together they show that the gate passes each edge with the exact latency and does not merge or drop short pulses. A fault is then applied in three situations: with the enable idle, with an access held low until the grace window expires, and with an access that ends inside the window. These cases separate an immediate close, a close forced by the timeout, and a close at the end of the access. A re-lowered enable after closure, a supply-only fault, and release from power-up reset show that the gate does not reopen early and does reopen at the right edge.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   typedef enum logic [1:0] {
      GS_PASS  = 2'd0,
      GS_GRACE = 2'd1,
      GS_BLOCK = 2'd2
   } gate_state_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_chk_stages
      $error("pfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pfg_grace_timer.sv
module pfg_grace_timer #(
   parameter int unsigned LIMIT = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_chk_limit
      $error("pfg_grace_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (start)            cnt <= '0;
      else if (run && !expired)  cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LAST);

   // R5: the window count never passes its final value
   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R5: a fresh window always begins from zero
   a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == '0));
endmodule

// File: rtl/pfg_gate_fsm.sv
module pfg_gate_fsm
   import pfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fault,
   input  logic ce_sync_n,
   input  logic expired,
   output logic start,
   output logic run,
   output logic ce_out_n,
   output logic gate_open
);
   gate_state_e state, nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         GS_PASS:  if (fault) nxt = ce_sync_n ? GS_BLOCK : GS_GRACE;
         GS_GRACE: if (ce_sync_n || expired) nxt = GS_BLOCK;
         GS_BLOCK: if (!fault) nxt = GS_PASS;
         default:  nxt = GS_BLOCK;
      endcase
   end

   assign start = (state == GS_PASS) && (nxt == GS_GRACE);
   assign run   = (state == GS_GRACE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= GS_BLOCK;
         ce_out_n  <= 1'b1;
         gate_open <= 1'b0;
      end else begin
         state     <= nxt;
         ce_out_n  <= (nxt == GS_BLOCK) | ce_sync_n;
         gate_open <= (nxt != GS_BLOCK);
      end
   end

   // R8: a low enable reaches the memory only through an open gate
   a_r8_low_only_open: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_out_n |-> gate_open);
   // R6: a closed gate with a standing fault stays closed and high
   a_r6_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && fault) |=> (!gate_open && ce_out_n));
   // R5: during the grace window the access is held low
   a_r5_grace_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == GS_GRACE) |-> (!ce_out_n && gate_open));
   // R3: in steady pass mode the output tracks the synchronized enable
   a_r3_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (state == GS_PASS && $past(state) == GS_PASS) |-> (ce_out_n == $past(ce_sync_n)));
   // R4: a fault seen while the enable is idle closes at that edge
   a_r4_idle_close: assert property (@(posedge clk) disable iff (!rst_n)
      (state == GS_PASS && fault && ce_sync_n) |=> (!gate_open && ce_out_n));
endmodule

// File: rtl/pfail_ce_gate.sv
module pfail_ce_gate #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GRACE_CYC   = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic sys_reset,
   input  logic ce_in_n,
   output logic ce_out_n,
   output logic gate_open
);
   localparam int unsigned PASS_LATENCY = SYNC_STAGES + 1;

   if (PASS_LATENCY < 3) begin : g_chk_latency
      $error("pfail_ce_gate: synchronizer must have at least two stages");
   end
   if (GRACE_CYC < 1) begin : g_chk_grace
      $error("pfail_ce_gate: GRACE_CYC must be at least 1");
   end

   logic ce_sync_n;
   logic fault;
   logic tmr_start;
   logic tmr_run;
   logic tmr_expired;

   assign fault = sys_reset | ~supply_ok;

   pfg_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ce_in_n),
      .q_sync  (ce_sync_n)
   );

   pfg_grace_timer #(
      .LIMIT (GRACE_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .run     (tmr_run),
      .expired (tmr_expired)
   );

   pfg_gate_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault     (fault),
      .ce_sync_n (ce_sync_n),
      .expired   (tmr_expired),
      .start     (tmr_start),
      .run       (tmr_run),
      .ce_out_n  (ce_out_n),
      .gate_open (gate_open)
   );

   // R1: reset leaves the memory deselected and the gate closed
   a_r1_reset_closed: assert property (@(posedge clk)
      !rst_n |=> (ce_out_n && !gate_open));
   // R9: with the supply low and no access pending, the path stays shut
   a_r9_supply_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_ok && !gate_open) |=> !gate_open);
endmodule

// File: tb/pfail_ce_gate_test.sv
module pfail_ce_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int GRACE      = 6;
   localparam int LAT        = 3;
   localparam int NVEC       = 24;
   localparam logic [NVEC-1:0] PATTERN = 24'b1101_0011_1000_0101_0110_1111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b1;
   logic sys_reset = 1'b1;
   logic ce_in_n = 1'b0;
   logic ce_out_n;
   logic gate_open;

   int checks = 0;
   int fails = 0;
   int r8_viol = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfail_ce_gate #(.SYNC_STAGES(2), .GRACE_CYC(GRACE)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .sys_reset (sys_reset),
      .ce_in_n   (ce_in_n),
      .ce_out_n  (ce_out_n),
      .gate_open (gate_open)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // R8 monitor, sampled away from the clock edge
   always @(negedge clk) if (rst_n && !done && ce_out_n === 1'b0 && gate_open !== 1'b1) r8_viol++;

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic hist [NVEC];
      // R1: reset state
      step(3);
      chk("R1 ce_out_n", ce_out_n, 1'b1);
      chk("R1 gate_open", gate_open, 1'b0);
      rst_n = 1'b1;
      // R2: fault persists after reset release, enable low
      step(8);
      chk("R2 ce_out_n", ce_out_n, 1'b1);
      chk("R2 gate_open", gate_open, 1'b0);
      // R7: release fault, synced enable is low
      sys_reset = 1'b0;
      step(1);
      chk("R7 gate_open", gate_open, 1'b1);
      chk("R7 ce_out_n", ce_out_n, 1'b0);
      ce_in_n = 1'b1;
      step(4);
      // R3: table walk of enable patterns
      for (int i = 0; i < NVEC + LAT; i++) begin
         @(negedge clk);
         if (i >= LAT) chk("R3 pass latency", ce_out_n, hist[i-LAT]);
         if (i < NVEC) begin
            hist[i] = PATTERN[i];
            ce_in_n = PATTERN[i];
         end else begin
            ce_in_n = 1'b1;
         end
      end
      step(4);
      // R4: fault with idle enable closes immediately
      sys_reset = 1'b1;
      step(1);
      chk("R4 gate_open", gate_open, 1'b0);
      chk("R4 ce_out_n", ce_out_n, 1'b1);
      sys_reset = 1'b0;
      ce_in_n = 1'b0;
      step(5);
      chk("R7 reopen low", ce_out_n, 1'b0);
      // R5: access held low until timeout
      sys_reset = 1'b1;
      step(1);
      chk("R5 grace start low", ce_out_n, 1'b0);
      chk("R5 grace open", gate_open, 1'b1);
      step(GRACE - 1);
      chk("R5 grace last low", ce_out_n, 1'b0);
      step(1);
      chk("R5 timeout high", ce_out_n, 1'b1);
      chk("R5 timeout closed", gate_open, 1'b0);
      // R6: enable returns low, gate stays shut
      ce_in_n = 1'b1;
      step(2);
      ce_in_n = 1'b0;
      step(6);
      chk("R6 stays high", ce_out_n, 1'b1);
      chk("R6 stays closed", gate_open, 1'b0);
      // R7: fault clears, reopen with low enable
      sys_reset = 1'b0;
      step(1);
      chk("R7 reopen", gate_open, 1'b1);
      chk("R7 follow", ce_out_n, 1'b0);
      step(2);
      // R5: access ends inside the window
      sys_reset = 1'b1;
      step(2);
      ce_in_n = 1'b1;
      step(2);
      chk("R5 still low", ce_out_n, 1'b0);
      step(1);
      chk("R5 early close high", ce_out_n, 1'b1);
      chk("R5 early close shut", gate_open, 1'b0);
      sys_reset = 1'b0;
      step(3);
      chk("R7 idle reopen", gate_open, 1'b1);
      // R9: supply fault only
      supply_ok = 1'b0;
      step(1);
      chk("R9 closed", gate_open, 1'b0);
      chk("R9 high", ce_out_n, 1'b1);
      ce_in_n = 1'b0;
      step(5);
      chk("R9 blocked", ce_out_n, 1'b1);
      supply_ok = 1'b1;
      step(1);
      chk("R9 recover", gate_open, 1'b1);
      // R8: gathered over the whole run
      chk("R8 low only when open", (r8_viol == 0), 1'b1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule